// File: doc/BRIEF.md
# I2C-Programmable Switch Register with Output Steering

This block is an I2C target that keeps a six-bit setting word and presents it on pins. Five bits of the word go through a 2:1 selector: with the select pin low the pins show the stored bits, and with it high they pass an external five-bit bus. The sixth bit drives a single output through a latch. The latch follows the stored bit while select is low and freezes when select goes high. An active-low override pin forces both outputs to zero, but only while select is low.

The bus side runs on a fast system clock that oversamples SCL and SDA. A controller addresses the target with the fixed pattern `10011` followed by two strap pins. It then writes one data byte, or reads the stored byte back. A write-protect pin blocks updates. Blocked writes are still acknowledged.

The bus state machine has eight states. IDLE waits for START. ADDR shifts in eight bits. After the eighth bit it goes to ADDR_ACK when the address matches, or to IGNORE when it does not. ADDR_ACK goes to RD_DATA when the direction bit is 1, or to WR_DATA when it is 0. WR_DATA goes to WR_ACK after eight bits, and WR_ACK returns to WR_DATA. RD_DATA goes to RD_ACK after eight bits. RD_ACK goes back to RD_DATA on a controller ACK, or to IGNORE on a NACK. From any state, START leads to ADDR and STOP leads to IDLE.

Top module: `cfg_switch_top`

## Requirements
- R1: With `sel`=0 and `force_n`=1, `mux_q` equals bits [4:0] of the stored word. With `sel`=1, `mux_q` equals `ext_bus`.
- R2: With `sel`=0 and `force_n`=1, `solo_q` equals bit 5 of the stored word. While `sel`=1, `solo_q` holds the value it had just before `sel` rose, even if the stored word changes.
- R3: With `force_n`=0 and `sel`=0, `mux_q` and `solo_q` are all zero. With `force_n`=0 and `sel`=1, `mux_q` follows `ext_bus` and `solo_q` keeps its latched value.
- R4: The target address is 7'b10011 followed by `addr_pins[1]` and `addr_pins[0]`, sent MSB first. The eighth bit is the direction: 0 = write, 1 = read. A matching address is acknowledged by pulling SDA low (`sda_oe`=1) during the ninth clock.
- R5: A non-matching address gets no acknowledge. The target never drives SDA for the rest of that transfer, and the stored word is unchanged.
- R6: A read returns {2'b00, stored[5:0]} MSB first, then releases SDA for the controller's acknowledge. An ACK repeats the same byte. A NACK ends driving.
- R7: The first data byte of a write is acknowledged. Its bits [5:0] become the stored word (bit 5 feeds `solo_q`, bits [4:0] feed the selector). Bits [7:6] are ignored.
- R8: A write while `wr_lock`=1 is still acknowledged but leaves the stored word unchanged.
- R9: Data bytes after the first one in a write are acknowledged and discarded.
- R10: A START at any point restarts address reception. A STOP returns to idle and releases SDA.
- R11: After reset the stored word is zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_pins | input | 2 | Strap pins, two low address bits |
| wr_lock | input | 1 | 1 blocks writes to the stored word |
| force_n | input | 1 | Active-low output override |
| sel | input | 1 | Selector and latch gate |
| ext_bus | input | 5 | External data passed when `sel`=1 |
| mux_q | output | 5 | Steered five-bit output |
| solo_q | output | 1 | Latched single output |

## Verification
The assertions check, on every cycle, several properties. The override zeroes the outputs whenever select is low. The single output stays steady while select stays high. The stored word never changes while write-protect is high. The word changes only on entry to the write-acknowledge state. SDA is released after STOP and while a transfer is ignored. Only the bench scenarios can show the protocol-level results: address matching against the straps, read-back ordering, ACK/NACK continuation, discarding of extra bytes, and recovery from a repeated START that arrives mid-byte. They also show the latched output holding an old value across a write made while select is high.

// File: rtl/cfg_switch_pkg.sv
package cfg_switch_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_now, scl_d, sda_d;

    // synchronizer chains, idle-high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_now;
            sda_d  <= sda_s;
        end
    end

    assign scl_now   = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_switch_fsm.sv
module cfg_switch_fsm
    import cfg_switch_pkg::*;
#(
    parameter int          DATA_W      = 6,
    parameter int          PIN_W       = 2,
    parameter int          FIX_W       = 5,
    parameter logic [FIX_W-1:0] FIXED_ADDR = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic              wr_lock,
    output logic              sda_oe,
    output logic [DATA_W-1:0] stored_q
);
    localparam int ADDR_W = FIX_W + PIN_W;

    bus_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rw_q, first_q, ack_q;
    logic              byte_in_done, addr_hit;

    assign byte_in_done = scl_fall && (cnt_q == CNT_W'(BYTE_W));
    assign addr_hit     = (shreg_q[BYTE_W-1 -: ADDR_W] == {FIXED_ADDR, addr_pins});

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_in_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_in_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt_q == CNT_W'(BYTE_W-1)) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = ack_q ? ST_RD_DATA : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifter, bit counter, stored word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            cnt_q    <= '0;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            ack_q    <= 1'b0;
            stored_q <= '0;
        end else if (start_det) begin
            cnt_q <= '0;
        end else if (!stop_det) begin
            unique case (state_q)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (byte_in_done) begin
                        rw_q <= shreg_q[0];
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q   <= '0;
                        first_q <= 1'b1;
                        shreg_q <= BYTE_W'(stored_q);
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (byte_in_done) begin
                        first_q <= 1'b0;
                        if (first_q && !wr_lock) stored_q <= shreg_q[DATA_W-1:0];
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) cnt_q <= '0;
                end
                ST_RD_DATA: begin
                    if (scl_fall && cnt_q != CNT_W'(BYTE_W-1)) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) ack_q <= ~sda_s;
                    else if (scl_fall) begin
                        cnt_q   <= '0;
                        shreg_q <= BYTE_W'(stored_q);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = ~shreg_q[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    p_lock_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> $stable(stored_q));

    p_commit_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stored_q) |-> state_q == ST_WR_ACK);

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det && !start_det |=> !sda_oe);

    p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IGNORE |-> !sda_oe);
endmodule

// File: rtl/cfg_switch_out.sv
module cfg_switch_out #(
    parameter int MUX_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           force_n,
    input  logic [MUX_W-1:0] ext_bus,
    input  logic [MUX_W:0]   stored,
    output logic [MUX_W-1:0] mux_q,
    output logic           solo_q
);
    logic shown_solo, lat_q;

    assign shown_solo = force_n & stored[MUX_W];

    // gate modelled synchronously: load the displayed bit while sel is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lat_q <= 1'b0;
        else if (!sel) lat_q <= shown_solo;
    end

    for (genvar b = 0; b < MUX_W; b++) begin : g_bit
        assign mux_q[b] = sel ? ext_bus[b] : (force_n & stored[b]);
    end

    assign solo_q = sel ? lat_q : shown_solo;

    p_override_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_n && !sel) |-> (mux_q == '0 && !solo_q));

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(solo_q));
endmodule

// File: rtl/cfg_switch_top.sv
module cfg_switch_top #(
    parameter int MUX_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_pins,
    input  logic             wr_lock,
    input  logic             force_n,
    input  logic             sel,
    input  logic [MUX_W-1:0] ext_bus,
    output logic [MUX_W-1:0] mux_q,
    output logic             solo_q
);
    localparam int DATA_W = MUX_W + 1;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] stored;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_switch_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_pins(addr_pins), .wr_lock(wr_lock),
        .sda_oe(sda_oe), .stored_q(stored)
    );

    cfg_switch_out #(.MUX_W(MUX_W)) u_out (
        .clk(clk), .rst_n(rst_n), .sel(sel), .force_n(force_n),
        .ext_bus(ext_bus), .stored(stored),
        .mux_q(mux_q), .solo_q(solo_q)
    );
endmodule

// File: tb/test_cfg_switch_top.sv
module test_cfg_switch_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_drv = 1'b1;
    logic sda_oe, sda_bus;
    logic [1:0] addr_pins = 2'b10;
    logic wr_lock = 1'b0, force_n = 1'b1, sel = 1'b0;
    logic [4:0] ext_bus = '0, mux_q;
    logic solo_q;

    int checks = 0, fails = 0;
    logic [5:0] model = '0;
    logic latch_m = 1'b0;

    always #4 clk = ~clk;
    assign sda_bus = sda_drv & ~sda_oe;

    cfg_switch_top i_cfg_switch_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_pins(addr_pins), .wr_lock(wr_lock), .force_n(force_n), .sel(sel),
        .ext_bus(ext_bus), .mux_q(mux_q), .solo_q(solo_q)
    );

    function automatic logic [4:0] exp_mux(logic s, logic f, logic [5:0] st, logic [4:0] e);
        return s ? e : (f ? st[4:0] : 5'd0);
    endfunction
    function automatic logic exp_solo(logic s, logic f, logic [5:0] st, logic l);
        return s ? l : (f & st[5]);
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic i2c_start;
        sda_drv = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
        sda_drv = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
    endtask
    task automatic i2c_stop;
        sda_drv = 1'b0; wclk(Q); scl = 1'b1; wclk(Q);
        sda_drv = 1'b1; wclk(2*Q);
    endtask
    task automatic put_bit(logic b);
        sda_drv = b; wclk(Q); scl = 1'b1; wclk(2*Q); scl = 1'b0; wclk(Q);
    endtask
    task automatic get_bit(output logic b);
        sda_drv = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
        b = sda_bus; wclk(Q); scl = 1'b0; wclk(Q);
    endtask
    task automatic put_byte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = ~a;
    endtask
    task automatic get_byte(logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic set_ctl(logic s, logic f, logic [4:0] e);
        @(negedge clk);
        if (!sel) latch_m = force_n & model[5];
        sel = s; force_n = f; ext_bus = e;
        wclk(2);
        @(negedge clk);
    endtask

    task automatic check_outs(string req);
        @(negedge clk);
        check(req, {3'd0, mux_q}, {3'd0, exp_mux(sel, force_n, model, ext_bus)});
        check(req, {7'd0, solo_q}, {7'd0, exp_solo(sel, force_n, model, latch_m)});
    endtask

    task automatic do_write(logic [7:0] v, logic lock);
        logic ack;
        wr_lock = lock;
        i2c_start;
        put_byte({5'b10011, addr_pins, 1'b0}, ack);
        check("R4 addr ack", {7'd0, ack}, 8'd1);
        put_byte(v, ack);
        check(lock ? "R8 locked ack" : "R7 data ack", {7'd0, ack}, 8'd1);
        i2c_stop;
        if (!lock) model = v[5:0];
        wr_lock = 1'b0;
    endtask

    task automatic do_read(string req);
        logic ack;
        logic [7:0] v;
        i2c_start;
        put_byte({5'b10011, addr_pins, 1'b1}, ack);
        check("R4 read addr ack", {7'd0, ack}, 8'd1);
        get_byte(1'b0, v);
        check(req, v, {2'b00, model});
        i2c_stop;
    endtask

    initial begin
        wclk(150000);
        fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        void'($urandom(32'd1234));
        wclk(10);
        rst_n = 1'b1;
        wclk(4);
        // R11 reset state
        check_outs("R11 reset outputs");
        check("R11 sda released", {7'd0, sda_oe}, 8'd0);

        // R7: bits 7:6 ignored; R1/R2 show the stored word
        do_write(8'hE5, 1'b0);
        check_outs("R7 R1 R2 after write");
        do_read("R6 read back");

        // R6: ACK repeats the byte, NACK ends
        i2c_start;
        put_byte({5'b10011, addr_pins, 1'b1}, ack);
        get_byte(1'b1, v);
        check("R6 first read byte", v, {2'b00, model});
        get_byte(1'b0, v);
        check("R6 repeated read byte", v, {2'b00, model});
        get_bit(ack);
        check("R6 released after NACK", {7'd0, ack}, 8'd1);
        i2c_stop;

        // R5: wrong strap bit
        i2c_start;
        put_byte({5'b10011, addr_pins[1], ~addr_pins[0], 1'b0}, ack);
        check("R5 no ack", {7'd0, ack}, 8'd0);
        put_byte(8'h00, ack);
        check("R5 no data ack", {7'd0, ack}, 8'd0);
        i2c_stop;
        check_outs("R5 word unchanged");

        // R8: write protect
        do_write(8'h0A, 1'b1);
        check_outs("R8 word unchanged");

        // R9: extra bytes discarded
        i2c_start;
        put_byte({5'b10011, addr_pins, 1'b0}, ack);
        put_byte(8'h11, ack);
        put_byte(8'h2E, ack);
        check("R9 extra byte ack", {7'd0, ack}, 8'd1);
        i2c_stop;
        model = 6'h11;
        check_outs("R9 first byte kept");

        // R10: START in mid-byte restarts address reception
        i2c_start;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        sda_drv = 1'b1; wclk(Q);
        do_write(8'h33, 1'b0);
        check_outs("R10 restart write");

        // R2: latch holds across a write while sel high
        do_write(8'h20, 1'b0);
        set_ctl(1'b1, 1'b1, 5'h0F);
        do_write(8'h05, 1'b0);
        check_outs("R2 latch holds");
        check("R2 held one", {7'd0, solo_q}, 8'd1);
        set_ctl(1'b0, 1'b1, 5'h0F);
        check_outs("R2 transparent again");

        // R3: override
        do_write(8'h3F, 1'b0);
        set_ctl(1'b0, 1'b0, 5'h15);
        check_outs("R3 forced zero");
        set_ctl(1'b1, 1'b0, 5'h0A);
        check_outs("R3 sel high under override");
        set_ctl(1'b0, 1'b1, 5'h0A);

        // random mix
        for (int n = 0; n < 16; n++) begin
            logic [7:0] rv;
            logic lk;
            rv = 8'($urandom);
            lk = ($urandom % 4) == 0;
            do_write(rv, lk);
            set_ctl(1'($urandom), 1'($urandom), 5'($urandom));
            check_outs("R1 R2 R3 random");
            do_read("R6 R7 R8 random read");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule